// File: doc/BRIEF.md
# SPI Slave Receiver with Low-Power Wakeup

This block is an 8-bit SPI slave for a small controller. It shifts in bytes from an external master and stores each one in a receive data register. It reports completion, overrun and mode-fault conditions as status flags, and it merges the enabled flags into one interrupt request level. The three pins SCK, MOSI and the active-low select are sampled into the system clock through two-flop synchronisers. The slave-select seen by the block comes either from the pin or from a select level that software sets in the control register. Software reaches control, status and data through a small register port with a two-bit address.

A power manager drives the halt and wait inputs, and the block drives a one-cycle wakeup pulse back to it. While the device is halted, reception continues and the flags still update, but register-port reads and writes are ignored. A completed byte can end halt only if the slave was selected when halt began. Every flag event can end wait. After a halt the slave treats its next byte as a throwaway resynchronising transfer.

Register map: address 0 is control, address 1 is status (read-only), and address 2 is data. Reading address 2 returns the received byte, and writing it loads the byte to transmit. Control bits are as follows. Bit 0 is interrupt enable. Bit 1 is master enable; the slave function works only while this bit is 0. Bit 2 selects the software select level instead of the pin. Bit 3 is that software select level, with 0 meaning selected. Status bits are: bit 0 transfer done, bit 1 mode fault, bit 2 overrun, bit 3 resync pending.

Top module: `spi_wake_slave`

## Requirements
- R1: After reset the control and status registers read 0x00, and irq_o and wake_o are low.
- R2: Transfers are clock polarity 0, phase 0, MSB first. MOSI is captured on the rising SCK edge, and MISO presents the transmit byte MSB first, changing after falling edges. After 8 rising edges the byte appears at address 2 and status bit 0 sets.
- R3: Status bits 0 and 2 clear only when software reads status and then reads data. A data read without a prior status read leaves them set.
- R4: If a byte completes while status bit 0 is already set, status bit 2 sets and the earlier byte stays in the data register.
- R5: irq_o is high exactly while control bit 0 is 1 and at least one of status bits 0, 1 or 2 is set.
- R6: If the slave is selected while control bit 1 is 1, status bit 1 sets and control bit 1 returns to 0. Software clears status bit 1 by reading status and then writing control.
- R7: With control bit 2 set, the select comes from control bit 3 (0 = selected), and the pin is ignored. With control bit 3 at 1, SCK edges store nothing.
- R8: While wait_i is high and control bit 0 is 1, a new transfer-done, overrun or mode-fault event gives one single-cycle pulse on wake_o.
- R9: While halt_i is high, only a new transfer-done event gives wake_o, and only if the slave was selected at halt entry. Overrun never wakes.
- R10: While halt_i is high, register-port writes and read side effects are ignored, but reception and flag updates continue.
- R11: When halt ends in slave mode, status bit 3 sets. The next completed byte is discarded without any flag and clears bit 3, and setting control bit 1 also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Active-low slave select pin |
| miso_o | output | 1 | Serial data out |
| halt_i | input | 1 | Device halted |
| wait_i | input | 1 | Device in wait mode |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address |
| irq_o | output | 1 | Combined interrupt request level |
| wake_o | output | 1 | Single-cycle wakeup pulse |

## Verification
A pin change takes two clocks to pass the synchronisers. The shifter registers the finished byte one clock after that, and the flags, data register and wake_o register one clock later. Flags and wake_o are therefore due four clocks after the eighth rising SCK edge. Register reads are combinational, and their side effects land at the next clock edge. The bench's behavioural model compares irq_o on every clock, but only after each stimulus has had at least four clocks to settle. It counts wake_o pulses on every clock and flags any pulse longer than one cycle.

// File: rtl/spi_wake_pkg.sv
package spi_wake_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int SYNC_N  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

    typedef struct packed {
        logic sel_lvl;   // bit 3
        logic sel_soft;  // bit 2
        logic master;    // bit 1
        logic irq_en;    // bit 0
    } ctrl_t;

    typedef struct packed {
        logic resync;    // bit 3
        logic ovr;       // bit 2
        logic modf;      // bit 1
        logic done;      // bit 0
    } stat_t;

    function automatic logic [DATA_W-1:0] widen4(input logic [3:0] v);
        return {{(DATA_W-4){1'b0}}, v};
    endfunction
endpackage

// File: rtl/spi_wake_sync.sv
module spi_wake_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    input  logic [WIDTH-1:0] rst_val_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{rst_val_i[g]}};
            else     chain <= {chain[STAGES-2:0], async_i[g]};
        end
        assign sync_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_wake_shifter.sv
module spi_wake_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sck,
    input  logic         mosi,
    input  logic         active,
    input  logic [W-1:0] tx_data,
    output logic         done_o,
    output logic [W-1:0] byte_o,
    output logic         miso_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          sck_q, act_q;
    logic [CW-1:0] cnt;
    logic [W-1:0]  rx_sh, tx_sh;
    logic          rise, fall;

    assign rise   = sck && !sck_q;
    assign fall   = !sck && sck_q;
    assign miso_o = tx_sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= 1'b0;
            act_q  <= 1'b0;
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            done_o <= 1'b0;
            byte_o <= '0;
        end else begin
            sck_q  <= sck;
            act_q  <= active;
            done_o <= 1'b0;
            if (!active) begin
                cnt <= '0;
            end else if (!act_q) begin
                cnt   <= '0;
                tx_sh <= tx_data;
            end else if (rise) begin
                rx_sh <= {rx_sh[W-2:0], mosi};
                if (cnt == LAST) begin
                    cnt    <= '0;
                    done_o <= 1'b1;
                    byte_o <= {rx_sh[W-2:0], mosi};
                    tx_sh  <= tx_data;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (fall && cnt != '0) begin
                tx_sh <= {tx_sh[W-2:0], 1'b0};
            end
        end
    end

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/spi_wake_regs.sv
module spi_wake_regs
    import spi_wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              selected_i,
    input  logic              halt_i,
    input  logic              wait_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] tx_o,
    output logic              irq_o,
    output logic              wake_o
);
    ctrl_t             ctrl;
    stat_t             st;
    logic [DATA_W-1:0] rx_data, tx_data;
    logic              halt_q, sel_at_halt, armed;

    logic bus_ok, stat_rd, data_rd, ctrl_wr, data_wr;
    logic clr_eo, clr_mf, accept, done_set, ovr_set, modf_set;
    logic halt_entry, halt_exit;

    assign bus_ok     = !halt_i;
    assign stat_rd    = bus_ok && rd_i && addr_i == A_STAT;
    assign data_rd    = bus_ok && rd_i && addr_i == A_DATA;
    assign ctrl_wr    = bus_ok && wr_i && addr_i == A_CTRL;
    assign data_wr    = bus_ok && wr_i && addr_i == A_DATA;
    assign clr_eo     = data_rd && armed;
    assign clr_mf     = ctrl_wr && armed;
    assign accept     = done_i && !st.resync;
    assign done_set   = accept && !st.done;
    assign ovr_set    = accept && st.done;
    assign modf_set   = selected_i && ctrl.master;
    assign halt_entry = halt_i && !halt_q;
    assign halt_exit  = !halt_i && halt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl        <= '0;
            st          <= '0;
            rx_data     <= '0;
            tx_data     <= '0;
            halt_q      <= 1'b0;
            sel_at_halt <= 1'b0;
            armed       <= 1'b0;
            wake_o      <= 1'b0;
        end else begin
            halt_q <= halt_i;
            if (halt_entry) sel_at_halt <= selected_i;

            if (ctrl_wr) ctrl <= ctrl_t'(wdata_i[3:0]);
            if (modf_set) ctrl.master <= 1'b0;
            if (data_wr) tx_data <= wdata_i;

            if (accept) st.done <= 1'b1;
            else if (clr_eo) st.done <= 1'b0;
            if (ovr_set) st.ovr <= 1'b1;
            else if (clr_eo) st.ovr <= 1'b0;
            if (modf_set) st.modf <= 1'b1;
            else if (clr_mf) st.modf <= 1'b0;
            if (done_set) rx_data <= byte_i;

            if (halt_exit && !ctrl.master) st.resync <= 1'b1;
            else if (ctrl.master) st.resync <= 1'b0;
            else if (done_i && st.resync) st.resync <= 1'b0;

            if (stat_rd && (st.done || st.ovr || st.modf)) armed <= 1'b1;
            else if (clr_eo || clr_mf) armed <= 1'b0;

            wake_o <= ctrl.irq_en &&
                      ((halt_i && halt_q && sel_at_halt && done_set) ||
                       (!halt_i && wait_i &&
                        (done_set || (ovr_set && !st.ovr) || (modf_set && !st.modf))));
        end
    end

    always_comb begin
        unique case (addr_i)
            A_CTRL:  rdata_o = widen4(ctrl);
            A_STAT:  rdata_o = widen4(st);
            A_DATA:  rdata_o = rx_data;
            default: rdata_o = '0;
        endcase
    end

    assign ctrl_o = ctrl;
    assign tx_o   = tx_data;
    assign irq_o  = ctrl.irq_en && (st.done || st.modf || st.ovr);

    p_ovr_after_done_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(st.ovr) |-> $past(st.done));
    p_modf_drops_master_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(st.modf) |-> !ctrl.master);
    p_halt_ctrl_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (halt_i && $past(halt_i)) |-> $stable(ctrl.irq_en) && $stable(tx_data));
    p_halt_wake_done_r9: assert property (@(posedge clk) disable iff (rst)
        (wake_o && halt_i && $past(halt_i)) |-> st.done && sel_at_halt);
    p_wake_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> !wake_o);
endmodule

// File: rtl/spi_wake_slave.sv
module spi_wake_slave
    import spi_wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              ss_n_i,
    output logic              miso_o,
    input  logic              halt_i,
    input  logic              wait_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              wake_o
);
    logic [2:0]        pins_s;
    logic              sck_s, mosi_s, ssn_s, selected, done;
    logic [DATA_W-1:0] rx_byte, tx_byte;
    ctrl_t             ctrl;

    spi_wake_sync #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_i  ({ss_n_i, mosi_i, sck_i}),
        .rst_val_i(3'b100),
        .sync_o   (pins_s)
    );
    assign {ssn_s, mosi_s, sck_s} = pins_s;

    assign selected = ctrl.sel_soft ? !ctrl.sel_lvl : !ssn_s;

    spi_wake_shifter #(.W(DATA_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .sck    (sck_s),
        .mosi   (mosi_s),
        .active (selected && !ctrl.master),
        .tx_data(tx_byte),
        .done_o (done),
        .byte_o (rx_byte),
        .miso_o (miso_o)
    );

    spi_wake_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .done_i    (done),
        .byte_i    (rx_byte),
        .selected_i(selected),
        .halt_i    (halt_i),
        .wait_i    (wait_i),
        .addr_i    (reg_addr_i),
        .wr_i      (reg_wr_i),
        .rd_i      (reg_rd_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .ctrl_o    (ctrl),
        .tx_o      (tx_byte),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ctrl.irq_en);
endmodule

// File: tb/test_spi_wake_slave.sv
module test_spi_wake_slave;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst = 1'b1;
    logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1, miso;
    logic       halt = 1'b0, wait_m = 1'b0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       irq, wake;

    int n_chk = 0, n_bad = 0;
    int wake_cnt = 0;
    bit wake_q = 0, settled = 0;
    // reference model state
    bit m_ien, m_done, m_modf, m_ovr;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_wake_slave i_spi_wake_slave (
        .clk(clk), .rst(rst), .sck_i(sck), .mosi_i(mosi), .ss_n_i(ss_n),
        .miso_o(miso), .halt_i(halt), .wait_i(wait_m), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (wake) wake_cnt++;
            if (wake && wake_q) chk("R8 pulse width", 2, 1);
            wake_q = wake;
            if (settled) chk("R5 irq level", irq, m_ien & (m_done | m_modf | m_ovr));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        idle(6);
        settled = 1;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        settled = 0;
        @(negedge clk); addr = a; wdata = d; wr = 1;
        @(negedge clk); wr = 0;
        settle();
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1; #1 d = rdata;
        @(negedge clk); rd = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic sw_clear();
        logic [7:0] t;
        settled = 0;
        reg_rd(2'd1, t);
        reg_rd(2'd2, t);
        m_done = 0; m_ovr = 0;
        settle();
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx_miso);
        settled = 0;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); mosi = tx[i];
            idle(4); rx_miso[i] = miso;
            sck = 1; idle(4); sck = 0;
        end
        idle(2);
    endtask

    task automatic set_ss(input logic v);
        settled = 0; @(negedge clk); ss_n = v; settle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk("watchdog", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, mi;
        int w0;
        idle(3); rst = 0; idle(2);
        // R1 reset state
        peek(2'd0, v); chk("R1 ctrl", v, 8'h00);
        peek(2'd1, v); chk("R1 status", v, 8'h00);
        chk("R1 irq", irq, 0); chk("R1 wake", wake, 0);
        settle();

        // R2 basic reception and MISO
        reg_wr(2'd0, 8'h01); m_ien = 1;
        reg_wr(2'd2, 8'hC5);
        set_ss(0);
        xfer(8'h3A, mi); m_done = 1; settle();
        chk("R2 miso byte", mi, 8'hC5);
        peek(2'd1, v); chk("R2 done flag", v, 8'h01);
        peek(2'd2, v); chk("R2 data", v, 8'h3A);
        chk("R8 no wake when running", wake_cnt, 0);
        sw_clear();
        peek(2'd1, v); chk("R3 cleared", v, 8'h00);

        // R3 data read without status read
        xfer(8'h5C, mi); m_done = 1; settle();
        reg_rd(2'd2, v); chk("R3 data", v, 8'h5C);
        idle(1); peek(2'd1, v); chk("R3 not cleared", v, 8'h01);
        sw_clear();

        // R4 overrun keeps first byte
        xfer(8'h11, mi); xfer(8'h22, mi); m_done = 1; m_ovr = 1; settle();
        peek(2'd1, v); chk("R4 ovr flag", v, 8'h05);
        peek(2'd2, v); chk("R4 first kept", v, 8'h11);
        sw_clear();
        peek(2'd1, v); chk("R3 ovr cleared", v, 8'h00);

        // R5 irq masked by enable
        reg_wr(2'd0, 8'h00); m_ien = 0;
        xfer(8'h99, mi); m_done = 1; settle();
        chk("R5 masked irq", irq, 0);
        sw_clear();
        reg_wr(2'd0, 8'h01); m_ien = 1;

        // R6 mode fault (pin selected)
        settled = 0;
        @(negedge clk); addr = 2'd0; wdata = 8'h03; wr = 1;
        @(negedge clk); wr = 0; m_modf = 1; settle();
        peek(2'd0, v); chk("R6 master dropped", v, 8'h01);
        peek(2'd1, v); chk("R6 modf flag", v, 8'h02);
        settled = 0; reg_rd(2'd1, v); reg_wr(2'd0, 8'h01); m_modf = 0; settle();
        peek(2'd1, v); chk("R6 modf cleared", v, 8'h00);

        // R8 wait wake on done
        wait_m = 1; w0 = wake_cnt;
        xfer(8'h66, mi); m_done = 1; settle();
        chk("R8 wait wake", wake_cnt - w0, 1);
        sw_clear();
        // R8 wait wake on mode fault
        w0 = wake_cnt; settled = 0;
        @(negedge clk); addr = 2'd0; wdata = 8'h03; wr = 1;
        @(negedge clk); wr = 0; m_modf = 1; settle();
        chk("R8 modf wakes wait", wake_cnt - w0, 1);
        settled = 0; reg_rd(2'd1, v); reg_wr(2'd0, 8'h01); m_modf = 0; settle();
        wait_m = 0;

        // R9/R10/R11 halt while selected
        settled = 0; @(negedge clk); halt = 1; settle();
        w0 = wake_cnt;
        reg_wr(2'd0, 8'h00);
        settled = 0; reg_rd(2'd1, v); reg_rd(2'd2, v);
        xfer(8'h77, mi); m_done = 1; settle();
        chk("R9 halt wake", wake_cnt - w0, 1);
        settled = 0; @(negedge clk); halt = 0; settle();
        peek(2'd0, v); chk("R10 write ignored", v, 8'h01);
        peek(2'd1, v); chk("R11 resync pending", v, 8'h09);
        peek(2'd2, v); chk("R10 data kept", v, 8'h77);
        sw_clear();
        xfer(8'hEE, mi); settle();
        peek(2'd1, v); chk("R11 discard no flag", v, 8'h00);
        peek(2'd2, v); chk("R11 discard data", v, 8'h77);
        xfer(8'h42, mi); m_done = 1; settle();
        peek(2'd2, v); chk("R11 after resync", v, 8'h42);
        sw_clear();

        // R9 overrun in halt does not wake again
        settled = 0; @(negedge clk); halt = 1; settle();
        w0 = wake_cnt;
        xfer(8'h01, mi); xfer(8'h02, mi); m_done = 1; m_ovr = 1; settle();
        chk("R9 one wake only", wake_cnt - w0, 1);
        peek(2'd1, v); chk("R10 flags in halt", v, 8'h05);
        settled = 0; @(negedge clk); halt = 0; settle();
        sw_clear();
        xfer(8'h00, mi); settle();

        // R9 not selected at halt entry
        set_ss(1);
        settled = 0; @(negedge clk); halt = 1; settle();
        set_ss(0);
        w0 = wake_cnt;
        xfer(8'h5A, mi); m_done = 1; settle();
        chk("R9 unselected no wake", wake_cnt - w0, 0);
        settled = 0; @(negedge clk); halt = 0; settle();
        sw_clear();
        // R11 leaving slave clears resync
        set_ss(1);
        reg_wr(2'd0, 8'h03);
        peek(2'd1, v); chk("R11 master clears resync", v, 8'h00);
        reg_wr(2'd0, 8'h01);

        // R7 software select
        reg_wr(2'd0, 8'h05);
        xfer(8'hB4, mi); m_done = 1; settle();
        peek(2'd2, v); chk("R7 soft select rx", v, 8'hB4);
        sw_clear();
        reg_wr(2'd0, 8'h0D);
        set_ss(0);
        xfer(8'h3C, mi); settle();
        peek(2'd1, v); chk("R7 deselected no flag", v, 8'h00);
        peek(2'd2, v); chk("R7 deselected data", v, 8'hB4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule